// File: doc/BRIEF.md
# Banked Interrupt Router

The router gathers peripheral interrupt lines in groups of 32 (one to four groups, chosen at build time) and steers each line to the interrupt trigger of one of four hardware threads. Every line passes through a two-stage synchroniser and is held in a per-line pending bit. A per-group sense register decides how each pending bit behaves. When the sense bit is 1 the pending bit mirrors the line. When the sense bit is 0 the pending bit latches a rising edge and stays set until software writes a 1 to it. A per-group enable register can block a line. A per-line route code picks the destination thread or leaves the line disconnected. A disconnected line is masked in effect, so software can rely on route codes alone when the enable registers are left out of the build.

Software reaches all of this state through a word-wide register port: a write strobe with address and data, and read data registered one clock after the address. Writing a 1 to an edge-mode pending bit inverts it. Software can clear the bit this way, and can also raise it to re-fire the interrupt. Writing a 1 to a level-mode pending bit forces it high for a single cycle, so the thread sees the interrupt again even when the line has already dropped. Each thread output is registered and is the OR of every line that is pending, enabled and routed to that thread.

The design has no sequencing state machine. Its only enumerated decode is the register-kind selector, with the values KIND_NONE, KIND_STATUS, KIND_SENSE, KIND_MASK and KIND_VECTOR. There are no transitions to name: each access is decoded in the cycle it is presented.

Top module: `irq_router`

## Requirements
- R1: After reset every thread output is 0 and every pending, sense, enable and route register reads 0.
- R2: Byte address map (bank b, source s): pending at 0x000+8b, sense at 0x040+8b, enable at 0x080+8b, route code of source s at 0x100+4s in bits [2:0]. Source s sits in bank s/32 at bit s%32. Any other address, and any bank or source beyond the configured count, reads 0 and ignores writes. Read data appears one clock after the address.
- R3: For an edge-mode source (sense bit 0), a rising input sets its pending bit, and the bit stays set after the input falls. The thread output responds in the 4th clock after the input changes.
- R4: On an edge-mode source, writing a 1 to the pending bit inverts it, and a 0-to-1 inversion raises the routed trigger again. Writing 0 has no effect.
- R5: For a level-mode source (sense bit 1), the pending bit follows the synchronised input, and so does the routed trigger, with the same 4-clock latency.
- R6: Writing a 1 to a level-mode pending bit forces that bit to 1 for exactly one cycle. With the input low, the routed trigger is high for one cycle, starting one clock after the write.
- R7: An enable bit of 0 blocks its source from every trigger, but the pending bit is still recorded. When the enable registers are left out of the build, the enable register reads all ones, writes to it are ignored, and every source is enabled.
- R8: Route code 0 disconnects a source. Codes 1, 2, 3 and 4 select thread 0, 1, 2 and 3. Codes 5 to 7 also disconnect the source.
- R9: Thread output n is the OR over all sources that are pending, enabled and routed to n. It changes one clock after the register write that caused the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_BANKS*32 | Peripheral interrupt lines, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the previous cycle's address |
| trig_out | output | 4 | One interrupt trigger per thread |

## Verification
The bench goes after the behaviours a near-miss design would get wrong. It times the trigger to the exact cycle after an input edge, so a design with a missing synchroniser stage would fire a cycle early. It checks that an edge-mode bit stays set after its line falls, which catches a design that lets the bit follow the line. It checks that a write of 0 leaves a pending bit alone and that a write of 1 inverts it, which catches a design that clears on any write or never re-fires. It checks that a level-mode re-signal lasts exactly one cycle, that route codes 5 to 7 reach no thread, and that two sources on one thread are ORed. A build without enable registers is checked to read all ones, and a bank outside the configured count is checked to read 0.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int LANES   = 32;
    localparam int THREADS = 4;
    localparam int VEC_W   = 3;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 10;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_STATUS,
        KIND_SENSE,
        KIND_MASK,
        KIND_VECTOR
    } reg_kind_e;

    // Route code to one-hot thread select; codes outside 1..THREADS select nothing.
    function automatic logic [THREADS-1:0] route_onehot(input logic [VEC_W-1:0] code);
        logic [THREADS-1:0] oh;
        oh = '0;
        for (int t = 0; t < THREADS; t++) begin
            if (int'(code) == t + 1) begin
                oh[t] = 1'b1;
            end
        end
        return oh;
    endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] line_i,
    input  logic [LANES-1:0] sense_i,
    input  logic [LANES-1:0] toggle_i,
    output logic [LANES-1:0] status_o
);

    logic [LANES-1:0] meta_q;
    logic [LANES-1:0] sync_q;
    logic [LANES-1:0] prev_q;
    logic [LANES-1:0] status_q;
    logic [LANES-1:0] rise;
    logic [LANES-1:0] edge_next;
    logic [LANES-1:0] level_next;

    assign rise       = sync_q & ~prev_q;
    assign edge_next  = (status_q ^ toggle_i) | rise;
    assign level_next = sync_q | toggle_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            sync_q   <= '0;
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            meta_q   <= line_i;
            sync_q   <= meta_q;
            prev_q   <= sync_q;
            status_q <= (sense_i & level_next) | (~sense_i & edge_next);
        end
    end

    assign status_o = status_q;

    // R3
    edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (|(rise & ~sense_i)) |=>
        ((status_q & $past(rise & ~sense_i)) == $past(rise & ~sense_i)));

    // R4
    edge_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(status_q) & ~$past(sense_i)
          & ~$past(rise | toggle_i)) == '0));

    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(sense_i & sync_q) & ~status_q) == '0));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter bit HAS_MASK  = 1'b1,
    localparam int NSRC     = NUM_BANKS * LANES,
    localparam int SRC_W    = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [REG_W-1:0]      wdata_i,
    input  logic [NSRC-1:0]       status_i,
    output logic [NSRC-1:0]       sense_o,
    output logic [NSRC-1:0]       mask_o,
    output logic [NSRC*VEC_W-1:0] vec_o,
    output logic [NSRC-1:0]       toggle_o,
    output logic [REG_W-1:0]      rdata_o
);

    reg_kind_e        kind;
    logic [2:0]       bank_f;
    logic [7:0]       vidx;
    logic [SRC_W-1:0] src_idx;
    logic [NSRC-1:0]  sense_q;
    logic [NSRC-1:0]  mask_q;
    logic [VEC_W-1:0] vec_q [NSRC];
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rdata_q;

    // Address decode: banked region in 0x000..0x0FF, per-source region above.
    always_comb begin
        kind    = KIND_NONE;
        bank_f  = addr_i[5:3];
        vidx    = addr_i[9:2] - 8'd64;
        src_idx = vidx[SRC_W-1:0];
        if (addr_i[9:8] == 2'b00) begin
            if (addr_i[2:0] == 3'b000 && int'(bank_f) < NUM_BANKS) begin
                unique case (addr_i[7:6])
                    2'b00:   kind = KIND_STATUS;
                    2'b01:   kind = KIND_SENSE;
                    2'b10:   kind = KIND_MASK;
                    default: kind = KIND_NONE;
                endcase
            end
        end else if (addr_i[1:0] == 2'b00 && int'(vidx) < NSRC) begin
            kind = KIND_VECTOR;
        end
    end

    // Write-one strobes toward the pending bits.
    always_comb begin
        toggle_o = '0;
        if (wr_i && kind == KIND_STATUS) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (int'(bank_f) == b) begin
                    toggle_o[b*LANES +: LANES] = wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
        end else if (wr_i && kind == KIND_SENSE) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (int'(bank_f) == b) begin
                    sense_q[b*LANES +: LANES] <= wdata_i;
                end
            end
        end
    end

    generate
        if (HAS_MASK) begin : g_mask
            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q <= '0;
                end else if (wr_i && kind == KIND_MASK) begin
                    for (int b = 0; b < NUM_BANKS; b++) begin
                        if (int'(bank_f) == b) begin
                            mask_q[b*LANES +: LANES] <= wdata_i;
                        end
                    end
                end
            end
        end else begin : g_nomask
            assign mask_q = '1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSRC; s++) begin
                vec_q[s] <= '0;
            end
        end else if (wr_i && kind == KIND_VECTOR) begin
            vec_q[src_idx] <= wdata_i[VEC_W-1:0];
        end
    end

    genvar gs;
    generate
        for (gs = 0; gs < NSRC; gs++) begin : g_vec_flat
            assign vec_o[gs*VEC_W +: VEC_W] = vec_q[gs];
        end
    endgenerate

    always_comb begin
        rd = '0;
        unique case (kind)
            KIND_STATUS: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (int'(bank_f) == b) rd = status_i[b*LANES +: LANES];
                end
            end
            KIND_SENSE: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (int'(bank_f) == b) rd = sense_q[b*LANES +: LANES];
                end
            end
            KIND_MASK: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (int'(bank_f) == b) rd = mask_q[b*LANES +: LANES];
                end
            end
            KIND_VECTOR: rd[VEC_W-1:0] = vec_q[src_idx];
            default:     rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd;
        end
    end

    assign sense_o = sense_q;
    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;

    // R2
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && kind == KIND_NONE) |=> ($stable(sense_q) && $stable(mask_q)));

endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_router_pkg::*;
#(
    parameter int NSRC = 128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       status_i,
    input  logic [NSRC-1:0]       mask_i,
    input  logic [NSRC*VEC_W-1:0] vec_i,
    output logic [THREADS-1:0]    trig_o
);

    logic [THREADS-1:0] hit;
    logic [THREADS-1:0] trig_q;

    always_comb begin
        hit = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (status_i[s] && mask_i[s]) begin
                hit = hit | route_onehot(vec_i[s*VEC_W +: VEC_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
        end else begin
            trig_q <= hit;
        end
    end

    assign trig_o = trig_q;

    // R9
    trig_source_chk: assert property (@(posedge clk) disable iff (rst)
        (|trig_q) |-> $past(|(status_i & mask_i)));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter bit HAS_MASK  = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BANKS*LANES-1:0]  irq_in,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [REG_W-1:0]            reg_wdata,
    output logic [REG_W-1:0]            reg_rdata,
    output logic [THREADS-1:0]          trig_out
);

    localparam int NSRC = NUM_BANKS * LANES;

    logic [NSRC-1:0]       status;
    logic [NSRC-1:0]       sense;
    logic [NSRC-1:0]       mask;
    logic [NSRC-1:0]       toggle;
    logic [NSRC*VEC_W-1:0] vec;

    irq_regs #(
        .NUM_BANKS (NUM_BANKS),
        .HAS_MASK  (HAS_MASK)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (reg_wr),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .status_i (status),
        .sense_o  (sense),
        .mask_o   (mask),
        .vec_o    (vec),
        .toggle_o (toggle),
        .rdata_o  (reg_rdata)
    );

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            irq_bank u_bank (
                .clk      (clk),
                .rst      (rst),
                .line_i   (irq_in[gb*LANES +: LANES]),
                .sense_i  (sense[gb*LANES +: LANES]),
                .toggle_i (toggle[gb*LANES +: LANES]),
                .status_o (status[gb*LANES +: LANES])
            );
        end
    endgenerate

    irq_route #(
        .NSRC (NSRC)
    ) u_route (
        .clk      (clk),
        .rst      (rst),
        .status_i (status),
        .mask_i   (mask),
        .vec_i    (vec),
        .trig_o   (trig_out)
    );

endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [127:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  trig_out;

    logic [31:0] irq_in_nm = '0;
    logic        nm_wr = 1'b0;
    logic [9:0]  nm_addr = '0;
    logic [31:0] nm_wdata = '0;
    logic [31:0] nm_rdata;
    logic [3:0]  nm_trig;

    int    cyc = 0;
    int    applied = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    irq_router #(.NUM_BANKS(4), .HAS_MASK(1'b1)) u_irq_router (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trig_out(trig_out)
    );

    irq_router #(.NUM_BANKS(1), .HAS_MASK(1'b0)) u_irq_router_nomask (
        .clk(clk), .rst(rst), .irq_in(irq_in_nm), .reg_wr(nm_wr),
        .reg_addr(nm_addr), .reg_wdata(nm_wdata),
        .reg_rdata(nm_rdata), .trig_out(nm_trig)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares every scoreboard item whose cycle has come.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due <= cyc) begin
                logic [31:0] act;
                case (sb[i].sel)
                    0:       act = {28'b0, trig_out};
                    1:       act = reg_rdata;
                    2:       act = {28'b0, nm_trig};
                    default: act = nm_rdata;
                endcase
                applied++;
                if (act !== sb[i].exp) begin
                    miscompares++;
                    $display("FAIL %s: actual %h expected %h", sb[i].tag, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_val(input int dly, input int sel, input logic [31:0] e, input string tag);
        item_t it;
        it.due = cyc + dly;
        it.sel = sel;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input int bus, input logic [9:0] a, input logic [31:0] d);
        if (bus == 0) begin
            reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        end else begin
            nm_wr = 1'b1; nm_addr = a; nm_wdata = d;
        end
        @(negedge clk);
        reg_wr = 1'b0;
        nm_wr  = 1'b0;
    endtask

    task automatic read_check(input int bus, input logic [9:0] a, input logic [31:0] e, input string tag);
        if (bus == 0) reg_addr = a;
        else          nm_addr = a;
        expect_val(1, (bus == 0) ? 1 : 3, e, tag);
        @(negedge clk);
    endtask

    task automatic trig_check(input int bus, input logic [3:0] e, input string tag);
        expect_val(1, (bus == 0) ? 0 : 2, {28'b0, e}, tag);
        @(negedge clk);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        trig_check(0, 4'b0000, "R1 trigger after reset");
        trig_check(1, 4'b0000, "R1 no-mask trigger after reset");
        read_check(0, 10'h000, 32'h0, "R1 pending bank0");
        read_check(0, 10'h040, 32'h0, "R1 sense bank0");
        read_check(0, 10'h080, 32'h0, "R1 enable bank0");
        read_check(0, 10'h100, 32'h0, "R1 route src0");

        // R2 map and read-back
        reg_write(0, 10'h080, 32'hFFFF_FFFF);
        read_check(0, 10'h080, 32'hFFFF_FFFF, "R2 enable bank0 readback");
        reg_write(0, 10'h10C, 32'h2);
        read_check(0, 10'h10C, 32'h2, "R2 route src3 readback");
        reg_write(0, 10'h048, 32'h0000_00F0);
        read_check(0, 10'h048, 32'h0000_00F0, "R2 sense bank1 readback");
        reg_write(0, 10'h0C0, 32'hFFFF_FFFF);
        read_check(0, 10'h0C0, 32'h0, "R2 unmapped kind");
        read_check(0, 10'h004, 32'h0, "R2 misaligned bank offset");
        read_check(0, 10'h300, 32'h0, "R2 route beyond sources");
        read_check(0, 10'h040, 32'h0, "R2 sense bank0 untouched");

        // R3 edge capture and latency (src3 routed to thread1)
        irq_in[3] = 1'b1;
        expect_val(3, 0, 32'h0, "R3 no trigger before 4th clock");
        expect_val(4, 0, 32'h2, "R3 trigger on 4th clock");
        tick(5);
        irq_in[3] = 1'b0;
        tick(6);
        trig_check(0, 4'b0010, "R3 pending held after line falls");
        read_check(0, 10'h000, 32'h8, "R3 pending bit 3");

        // R4 write-one inverts, write-zero ignored
        reg_write(0, 10'h000, 32'h0);
        trig_check(0, 4'b0010, "R4 write of zero ignored");
        read_check(0, 10'h000, 32'h8, "R4 pending unchanged by zero");
        reg_write(0, 10'h000, 32'h8);
        trig_check(0, 4'b0000, "R4 write one clears");
        reg_write(0, 10'h000, 32'h8);
        trig_check(0, 4'b0010, "R4 write one re-fires");

        // R7 enable blocks trigger but keeps pending
        reg_write(0, 10'h080, 32'hFFFF_FFF7);
        trig_check(0, 4'b0000, "R7 disabled source blocked");
        read_check(0, 10'h000, 32'h8, "R7 pending kept while disabled");
        reg_write(0, 10'h080, 32'hFFFF_FFFF);
        trig_check(0, 4'b0010, "R7 re-enabled source");

        // R8 route codes
        reg_write(0, 10'h10C, 32'h5);
        trig_check(0, 4'b0000, "R8 code 5 disconnects");
        reg_write(0, 10'h10C, 32'h7);
        trig_check(0, 4'b0000, "R8 code 7 disconnects");
        reg_write(0, 10'h10C, 32'h4);
        trig_check(0, 4'b1000, "R8 code 4 to thread3");
        reg_write(0, 10'h10C, 32'h1);
        trig_check(0, 4'b0001, "R8 code 1 to thread0");
        reg_write(0, 10'h10C, 32'h0);
        trig_check(0, 4'b0000, "R8 code 0 disconnects");
        reg_write(0, 10'h000, 32'h8);
        read_check(0, 10'h000, 32'h0, "R4 pending cleared");

        // R5 level source: src36 (bank1 bit4) to thread2
        reg_write(0, 10'h190, 32'h3);
        reg_write(0, 10'h088, 32'hFFFF_FFFF);
        irq_in[36] = 1'b1;
        expect_val(3, 0, 32'h0, "R5 level not before 4th clock");
        expect_val(4, 0, 32'h4, "R5 level trigger");
        tick(5);
        read_check(0, 10'h008, 32'h10, "R5 level pending");
        irq_in[36] = 1'b0;
        expect_val(4, 0, 32'h0, "R5 level drops with line");
        tick(5);
        read_check(0, 10'h008, 32'h0, "R5 level pending cleared");

        // R6 level re-signal pulse
        reg_write(0, 10'h008, 32'h10);
        expect_val(1, 0, 32'h4, "R6 one-cycle re-signal");
        expect_val(2, 0, 32'h0, "R6 re-signal ends");
        tick(3);

        // R9 OR of sources per thread
        reg_write(0, 10'h10C, 32'h3);
        reg_write(0, 10'h000, 32'h8);
        trig_check(0, 4'b0100, "R9 src3 to thread2");
        reg_write(0, 10'h098, 32'hFFFF_FFFF);
        reg_write(0, 10'h290, 32'h1);
        reg_write(0, 10'h018, 32'h10);
        trig_check(0, 4'b0101, "R9 two threads active");
        reg_write(0, 10'h000, 32'h8);
        trig_check(0, 4'b0001, "R9 thread2 released");
        reg_write(0, 10'h018, 32'h10);
        trig_check(0, 4'b0000, "R9 all released");

        // R7 build without enable registers
        reg_write(1, 10'h114, 32'h4);
        irq_in_nm[5] = 1'b1;
        expect_val(4, 2, 32'h8, "R7 no-mask build enabled");
        tick(5);
        reg_write(1, 10'h080, 32'h0);
        trig_check(1, 4'b1000, "R7 enable write ignored");
        read_check(1, 10'h080, 32'hFFFF_FFFF, "R7 enable reads ones");
        read_check(1, 10'h008, 32'h0, "R2 bank beyond count");

        tick(6);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: all requirements, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

endmodule